// File: doc/BRIEF.md
# Double-Buffered Four-Channel Code Register Bank

This block is the digital front of a four-channel converter. A shared 8-bit data bus and a 2-bit channel select feed four first-stage (input) registers. An active-low write strobe steers bus data into the selected first stage. An active-low load strobe, common to all channels, moves every first stage into its second-stage (output) register at once. Only the second stages drive the four output codes. Software can therefore stage new values channel by channel and then change all four outputs in the same cycle.

The strobes behave like level-sensitive latch enables, but the design is fully clocked. Both strobes, the select and the bus pass through two register stages before they are used. While a strobe is held low, the stage it controls is transparent. This is modelled as a combinational bypass in the same cycle, and the register keeps following the bypass value on every clock. When the strobe returns high, the register keeps the last value it followed.

Top module: `quad_dbuf_regbank`

## Requirements
- R1: While `rst_n` is low, all four first stages and all four second stages are zero, so `code_o` reads 0.
- R2: Select value 0, 1, 2 and 3 addresses channel A, B, C and D. Channel k is presented on `code_o[8k+7:8k]`. Bus bit 7 is the most significant bit, and codes are straight binary.
- R3: While the synchronized write strobe is low, the selected first stage follows the bus. After the strobe rises, it keeps the last value it followed, and later bus changes have no effect on it.
- R4: While the synchronized load strobe stays high, `code_o` does not change, whatever happens on the write strobe, select or bus.
- R5: When the synchronized load strobe rises, all four second stages capture their first stages in the same cycle.
- R6: While the synchronized load strobe is low, each channel's output equals its own first stage.
- R7: While both synchronized strobes are low, the selected channel's output equals the bus value.
- R8: With both strobes high, neither register stage changes.
- R9: Strobes, select and bus are each delayed by two register stages. A pin change sampled at clock edge k is first visible on `code_o` after edge k+1.
- R10: If both strobes rise in the same cycle, the second stage of the written channel holds the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 8 | Shared data bus |
| chan_sel | input | 2 | Channel select |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low load strobe, shared by all channels |
| code_o | output | 32 | Four output codes, channel A in the low byte |

## Verification
Staged writes to each channel with the load strobe held high show that the outputs stay untouched. A following load pulse shows that all channels update together and that each address lands in its own channel. Bus sweeps with the load strobe held low tell a transparent output path apart from a latched one, and they show that the two-cycle latency counts one cycle per synchronizer stage. A case where both strobes rise in the same cycle, and bus changes after a write has closed, separate a correct closing edge from one that takes the value a cycle early or a cycle late.

// File: rtl/quad_dbuf_regbank.sv
module quad_dbuf_regbank #(
  parameter int W = 8,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   bus_d,
  input  logic [1:0]     chan_sel,
  input  logic           wr_n,
  input  logic           ld_n,
  output logic [N*W-1:0] code_o
);
  localparam int AW = 2;

  logic [1:0]   wr_sy, ld_sy;
  logic [W-1:0] d_p1, d_p2;
  logic [AW-1:0] a_p1, a_p2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sy <= 2'b11;
      ld_sy <= 2'b11;
      d_p1  <= '0;
      d_p2  <= '0;
      a_p1  <= '0;
      a_p2  <= '0;
    end else begin
      wr_sy <= {wr_sy[0], wr_n};
      ld_sy <= {ld_sy[0], ld_n};
      d_p1  <= bus_d;
      d_p2  <= d_p1;
      a_p1  <= chan_sel;
      a_p2  <= a_p1;
    end
  end

  wire wr_q = wr_sy[1];
  wire ld_q = ld_sy[1];

  for (genvar ch = 0; ch < N; ch++) begin : g_ch
    logic [W-1:0] in_r, dac_r;
    wire          hit  = !wr_q && (a_p2 == AW'(ch));
    wire [W-1:0]  view = hit ? d_p2 : in_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_r  <= '0;
        dac_r <= '0;
      end else begin
        if (hit)   in_r  <= d_p2;
        if (!ld_q) dac_r <= view;
      end
    end

    assign code_o[ch*W +: W] = ld_q ? dac_r : view;
  end
endmodule

// File: rtl/quad_dbuf_regbank_chk.sv
module quad_dbuf_regbank_chk #(
  parameter int W = 8,
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_q,
  input logic           ld_q,
  input logic [1:0]     a_p2,
  input logic [W-1:0]   d_p2,
  input logic [N*W-1:0] code_o
);
  // R1
  always_comb begin
    if (rst_n == 1'b0) begin
      reset_zero_chk: assert (code_o == '0);
    end
  end

  // R4
  ld_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && $past(ld_q)) |-> $stable(code_o));

  // R5
  ld_release_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_q) |-> $stable(code_o));

  // R6
  ld_open_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_q && wr_q && $past(!ld_q) && $past(wr_q)) |-> $stable(code_o));

  // R7
  both_open_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_q && !wr_q) |-> (code_o[a_p2*W +: W] == d_p2));
endmodule

bind quad_dbuf_regbank quad_dbuf_regbank_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_q(wr_q), .ld_q(ld_q),
  .a_p2(a_p2), .d_p2(d_p2), .code_o(code_o)
);

// File: tb/test_quad_dbuf_regbank.sv
module test_quad_dbuf_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_d = '0;
  logic [1:0]  chan_sel = '0;
  logic        wr_n = 1'b1;
  logic        ld_n = 1'b1;
  logic [31:0] code_o;

  quad_dbuf_regbank i_quad_dbuf_regbank (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .chan_sel(chan_sel),
    .wr_n(wr_n), .ld_n(ld_n), .code_o(code_o)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  int in_m[4];
  int out_m[4];
  int q_wr[$];
  int q_ld[$];
  int q_sel[$];
  int q_d[$];

  function automatic int view_m(int ch);
    if (q_wr[0] == 0 && q_sel[0] == ch) return q_d[0];
    return in_m[ch];
  endfunction

  function automatic int exp_code(int ch);
    if (q_ld[0] == 0) return view_m(ch);
    return out_m[ch];
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      in_m[c] = 0;
      out_m[c] = 0;
    end
    q_wr  = '{1, 1};
    q_ld  = '{1, 1};
    q_sel = '{0, 0};
    q_d   = '{0, 0};
  endtask

  task automatic model_edge();
    int nv[4];
    for (int c = 0; c < 4; c++) nv[c] = view_m(c);
    for (int c = 0; c < 4; c++) if (q_ld[0] == 0) out_m[c] = nv[c];
    if (q_wr[0] == 0) in_m[q_sel[0]] = q_d[0];
    void'(q_wr.pop_front());  q_wr.push_back(int'(wr_n));
    void'(q_ld.pop_front());  q_ld.push_back(int'(ld_n));
    void'(q_sel.pop_front()); q_sel.push_back(int'(chan_sel));
    void'(q_d.pop_front());   q_d.push_back(int'(bus_d));
  endtask

  task automatic compare(string tag);
    vectors++;
    for (int c = 0; c < 4; c++) begin
      if (int'(code_o[c*8 +: 8]) != exp_code(c)) begin
        misses++;
        $display("FAIL %s ch%0d: actual %02h expected %02h", tag, c,
                 code_o[c*8 +: 8], exp_code(c));
      end
    end
  endtask

  task automatic step(input logic w, input logic l, input logic [1:0] s,
                      input logic [7:0] d, input string tag);
    wr_n = w; ld_n = l; chan_sel = s; bus_d = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1, 1, chan_sel, bus_d, tag);
  endtask

  task automatic stage(logic [1:0] s, logic [7:0] d, string tag);
    step(0, 1, s, d, tag);
    step(0, 1, s, d, tag);
    step(1, 1, s, d, tag);
    idle(3, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    idle(3, "R8");
    // R4 / R2: stage distinct codes, outputs must stay at zero
    stage(2'd0, 8'h5A, "R4");
    stage(2'd1, 8'h81, "R2");
    stage(2'd2, 8'h3C, "R2");
    stage(2'd3, 8'hFF, "R2");
    // R5: one load pulse copies every channel at once
    step(1, 0, 2'd0, 8'h00, "R5");
    step(1, 0, 2'd0, 8'h00, "R5");
    idle(4, "R5");
    // R3: bus changes after write closes are ignored
    step(0, 1, 2'd2, 8'h66, "R3");
    step(1, 1, 2'd2, 8'h66, "R3");
    step(1, 1, 2'd2, 8'h99, "R3");
    step(1, 1, 2'd1, 8'h12, "R3");
    idle(2, "R3");
    step(1, 0, 2'd0, 8'h00, "R3");
    idle(4, "R3");
    // R9 / R6: load held open, outputs track first stages two edges later
    step(1, 0, 2'd0, 8'h00, "R6");
    step(1, 0, 2'd0, 8'h00, "R6");
    step(0, 0, 2'd0, 8'h01, "R9");
    step(0, 0, 2'd0, 8'h80, "R9");
    step(1, 0, 2'd0, 8'h80, "R9");
    step(1, 0, 2'd2, 8'h44, "R6");
    step(1, 0, 2'd2, 8'h44, "R6");
    // R7: both open, selected output follows bus
    step(0, 0, 2'd1, 8'h01, "R7");
    step(0, 0, 2'd1, 8'h02, "R7");
    step(0, 0, 2'd1, 8'hFE, "R7");
    step(0, 0, 2'd3, 8'hC3, "R7");
    step(0, 0, 2'd3, 8'h0F, "R7");
    // R10: both strobes rise together
    step(1, 1, 2'd3, 8'hAA, "R10");
    step(1, 1, 2'd0, 8'h55, "R10");
    idle(4, "R10");
    // R8: bus and select churn with both strobes high
    for (int i = 0; i < 8; i++) step(1, 1, 2'(i), 8'(i * 37), "R8");
    idle(2, "R8");
    // R4: write while load high leaves outputs
    stage(2'd1, 8'h00, "R4");
    step(1, 0, 2'd0, 8'h00, "R5");
    idle(4, "R5");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule